// File: doc/BRIEF.md
# UART Special-Character Interrupt Unit

This unit watches what a UART receiver delivers and the raw receive line. It records six kinds of event in a sticky status register. Four events are matches of a received character against the configured XON and XOFF characters. The fifth is a line break. The sixth is an address character arriving in 9-bit multidrop mode.

Software reads the status register through a simple read port. The read returns the current bits, and all bits clear at the following clock edge. A per-bit enable mask reduces the status bits to one summary interrupt line. Elsewhere in the chip, that line drives bit 1 of the top-level interrupt status.

Received characters arrive on a valid/ready stream. The unit never applies back-pressure: `rx_ready` is always 1, so a character is consumed in every cycle where `rx_valid` is 1. Mode pins, the read port and the interrupt line are plain signals.

Top module: `uart_spchar_irq`

## Requirements
- R1: After reset all six status bits are 0 and `spchar_irq` is low.
- R2: The register layout is as follows.
  - Bit 0 is the XON1 match, bit 1 the XON2 match, bit 2 the XOFF1 match and bit 3 the XOFF2 match.
  - Bit 4 is break and bit 5 is the multidrop address flag.
  - Bits 7:6 always read 0.
  - The register is at read address 0x06. `rd_data` shows it combinationally while `rd_en` is high with that address.
  - A read of any other address returns 0 and leaves the status unchanged.
- R3: A read of address 0x06 clears every status bit at the next clock edge. Without such a read, a set bit stays set.
- R4: An event in the same cycle as a clearing read leaves its bit set after the read.
- R5: With `spchar_en`=1, a consumed character whose low 8 bits equal a configured XON/XOFF character sets that character's bit. The ninth data bit plays no part in the match. If the character equals several configured characters, all of their bits set.
- R6: With `spchar_en`=0, bits 3:0 never set.
- R7: Bit 5 sets when a character with `rx_data[8]`=1 is consumed while `multidrop_en`=1. A ninth bit of 0, or `multidrop_en`=0, leaves bit 5 clear.
- R8: Bit 4 sets on the tick that takes the count of `bit_tick` pulses seen while `rx_line` is low to L+1. L is computed as follows:
  - L = 1 + (5 + `data_bits`) + `parity_en` + (`two_stop` ? 2 : 1).
  - `data_bits` encodes 0..3 as 5..8 data bits.
- R9: Break is flagged only once per low period. Detection re-arms after `rx_line` has been high for at least one cycle.
- R10: `spchar_irq` is the OR over n of status bit n AND `irq_mask[n]`. It follows the status bits and the mask.
- R11: `rx_ready` is always 1, and a cycle with `rx_valid`=0 sets no character bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character valid |
| rx_ready | output | 1 | Always 1; the unit never stalls |
| rx_data | input | 9 | Received character, bit 8 is the ninth bit |
| xon1_char | input | 8 | Configured first XON character |
| xon2_char | input | 8 | Configured second XON character |
| xoff1_char | input | 8 | Configured first XOFF character |
| xoff2_char | input | 8 | Configured second XOFF character |
| spchar_en | input | 1 | Enables XON/XOFF matching |
| multidrop_en | input | 1 | Enables 9-bit multidrop address flagging |
| data_bits | input | 2 | Data bits per character minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits when 1, one when 0 |
| rx_line | input | 1 | Raw receive line, idle high |
| bit_tick | input | 1 | One pulse per bit time |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Read data |
| irq_mask | input | 6 | Per-bit interrupt enable |
| spchar_irq | output | 1 | Summary interrupt |

## Verification
On every cycle, the assertions check the following:
- Set bits stay set until a read.
- A read with no coincident event empties the register, and the upper read bits stay zero.
- A zero mask keeps the interrupt low.
- Disabled modes freeze their bits.
- A break pulse never repeats on consecutive cycles and never occurs without prior low line.

Only the bench scenarios can show the following:
- Which bit a given character sets, including the double match and the ignored ninth bit.
- That break fires on exactly the L+1th tick for different frame formats.
- That one bit survives a coincident read.
- That detection re-arms only after the line goes high.

// File: rtl/spchar_pkg.sv
package spchar_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int FLAG_XON1  = 0;
  localparam int FLAG_XON2  = 1;
  localparam int FLAG_XOFF1 = 2;
  localparam int FLAG_XOFF2 = 3;
  localparam int FLAG_BRK   = 4;
  localparam int FLAG_ADDR  = 5;
  localparam int NUM_MATCH  = 4;
  localparam int CHAR_W     = 8;
  localparam int REG_W      = 8;
  // longest frame: start + 8 data + parity + 2 stop
  localparam int MAX_FRAME  = 12;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/spchar_match.sv
module spchar_match
  import spchar_pkg::*;
(
  input  logic                  chr_fire,
  input  logic [CHAR_W:0]       chr_data,
  input  logic [NUM_MATCH*CHAR_W-1:0] ref_chars,
  input  logic                  spchar_en,
  input  logic                  multidrop_en,
  output logic [NUM_MATCH-1:0]  hit_vec,
  output logic                  addr_hit
);
  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
    assign hit_vec[g] = chr_fire && spchar_en &&
                        (chr_data[CHAR_W-1:0] == ref_chars[g*CHAR_W +: CHAR_W]);
  end
  assign addr_hit = chr_fire && multidrop_en && chr_data[CHAR_W];
endmodule

// File: rtl/spchar_break_det.sv
module spchar_break_det
  import spchar_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_FRAME + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       bit_tick,
  input  logic [1:0] data_bits,
  input  logic       parity_en,
  input  logic       two_stop,
  output logic       brk_evt
);
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] frame_len;
  logic             armed;

  always_comb begin
    frame_len = CNT_W'(6) + CNT_W'(data_bits) + CNT_W'(parity_en)
              + (two_stop ? CNT_W'(2) : CNT_W'(1));
  end

  assign brk_evt = !rx_line && bit_tick && armed && (low_cnt == frame_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      armed   <= 1'b1;
    end else if (rx_line) begin
      low_cnt <= '0;
      armed   <= 1'b1;
    end else if (bit_tick && armed) begin
      if (low_cnt == frame_len) begin
        low_cnt <= '0;
        armed   <= 1'b0;
      end else begin
        low_cnt <= low_cnt + CNT_W'(1);
      end
    end
  end

  assert_break_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !brk_evt);
  assert_break_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> $past(!rx_line));
endmodule

// File: rtl/spchar_status.sv
module spchar_status
  import spchar_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  logic      clr,
  output flag_vec_t status
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)            status[g] <= 1'b0;
      else if (set_vec[g])   status[g] <= 1'b1;
      else if (clr)          status[g] <= 1'b0;
    end
  end

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status)));
  assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec == '0) |=> (status == '0));
  assert_event_survives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/uart_spchar_irq.sv
module uart_spchar_irq
  import spchar_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter logic [4:0]  STATUS_ADDR = 5'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [8:0]        rx_data,
  input  logic [7:0]        xon1_char,
  input  logic [7:0]        xon2_char,
  input  logic [7:0]        xoff1_char,
  input  logic [7:0]        xoff2_char,
  input  logic              spchar_en,
  input  logic              multidrop_en,
  input  logic [1:0]        data_bits,
  input  logic              parity_en,
  input  logic              two_stop,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [5:0]        irq_mask,
  output logic              spchar_irq
);
  localparam int PAD_W = REG_W - NUM_FLAGS;

  logic                 chr_fire;
  logic                 rd_hit;
  logic [NUM_MATCH-1:0] hit_vec;
  logic                 addr_hit;
  logic                 brk_evt;
  flag_vec_t            set_vec;
  flag_vec_t            status;

  assign rx_ready = 1'b1;
  assign chr_fire = rx_valid && rx_ready;
  assign rd_hit   = rd_en && (rd_addr == ADDR_W'(STATUS_ADDR));

  spchar_match u_match (
    .chr_fire     (chr_fire),
    .chr_data     (rx_data),
    .ref_chars    ({xoff2_char, xoff1_char, xon2_char, xon1_char}),
    .spchar_en    (spchar_en),
    .multidrop_en (multidrop_en),
    .hit_vec      (hit_vec),
    .addr_hit     (addr_hit)
  );

  spchar_break_det u_brk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .bit_tick  (bit_tick),
    .data_bits (data_bits),
    .parity_en (parity_en),
    .two_stop  (two_stop),
    .brk_evt   (brk_evt)
  );

  assign set_vec = {addr_hit, brk_evt, hit_vec};

  spchar_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (rd_hit),
    .status  (status)
  );

  assign rd_data    = rd_hit ? {{PAD_W{1'b0}}, status} : '0;
  assign spchar_irq = |(status & irq_mask);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);
  assert_mask_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !spchar_irq);
  assert_spchar_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!spchar_en && !rd_en) |=> $stable(status[3:0]));
  assert_addr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!multidrop_en && !rd_en) |=> $stable(status[5]));
endmodule

// File: tb/uart_spchar_irq_tb_top.sv
module uart_spchar_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [8:0] rx_data = '0;
  logic spchar_en = 1'b0, multidrop_en = 1'b0;
  logic [1:0] data_bits = 2'd3;
  logic parity_en = 1'b0, two_stop = 1'b0;
  logic rx_line = 1'b1, bit_tick = 1'b0;
  logic rd_en = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] irq_mask = '0;
  logic spchar_irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  uart_spchar_irq dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .xon1_char(8'h11), .xon2_char(8'h22),
    .xoff1_char(8'h13), .xoff2_char(8'h22), .spchar_en(spchar_en),
    .multidrop_en(multidrop_en), .data_bits(data_bits), .parity_en(parity_en),
    .two_stop(two_stop), .rx_line(rx_line), .bit_tick(bit_tick),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_mask(irq_mask), .spchar_irq(spchar_irq)
  );

  // {spchar_en, multidrop_en, rx_data[8:0], expected status[5:0]}
  localparam logic [16:0] VEC [9] = '{
    {1'b1, 1'b0, 9'h011, 6'h01},  // R5 XON1
    {1'b1, 1'b0, 9'h022, 6'h0A},  // R5 XON2 and XOFF2 together
    {1'b1, 1'b0, 9'h013, 6'h04},  // R5 XOFF1
    {1'b1, 1'b0, 9'h111, 6'h01},  // R5 ninth bit ignored
    {1'b0, 1'b0, 9'h011, 6'h00},  // R6 detection off
    {1'b0, 1'b1, 9'h155, 6'h20},  // R7 address char
    {1'b0, 1'b1, 9'h055, 6'h00},  // R7 data char
    {1'b1, 1'b1, 9'h113, 6'h24},  // R5 R7 both
    {1'b1, 1'b0, 9'h044, 6'h00}   // R5 no match
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [8:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // drives a read at negedge, samples combinational data, releases next negedge
  task automatic do_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_mask = 6'h3F;
    #1;
    check("R1 irq after reset", {7'd0, spchar_irq}, 8'h00);
    do_read(5'h06, d);
    check("R1 status after reset", d, 8'h00);
    check("R11 ready", {7'd0, rx_ready}, 8'h01);

    for (int v = 0; v < 9; v++) begin
      spchar_en    = VEC[v][16];
      multidrop_en = VEC[v][15];
      send_char(VEC[v][14:6]);
      do_read(5'h06, d);
      check($sformatf("R5/R6/R7 vector %0d", v), d, {2'b00, VEC[v][5:0]});
    end
    do_read(5'h06, d);
    check("R3 cleared after read", d, 8'h00);

    // R11: no valid, no effect
    spchar_en = 1'b1; multidrop_en = 1'b0;
    @(negedge clk); rx_data = 9'h011; rx_valid = 1'b0;
    @(negedge clk);
    do_read(5'h06, d);
    check("R11 idle data ignored", d, 8'h00);

    // R2 other address, R3 sticky, R10 mask
    send_char(9'h011);
    repeat (3) @(negedge clk);
    do_read(5'h05, d);
    check("R2 other address reads 0", d, 8'h00);
    irq_mask = 6'h00; #1;
    check("R10 mask off", {7'd0, spchar_irq}, 8'h00);
    irq_mask = 6'h02; #1;
    check("R10 other bit masked", {7'd0, spchar_irq}, 8'h00);
    irq_mask = 6'h01; #1;
    check("R10 enabled bit", {7'd0, spchar_irq}, 8'h01);
    do_read(5'h06, d);
    check("R2 R3 bit kept until read", d, 8'h01);
    #1;
    check("R10 irq drops after clear", {7'd0, spchar_irq}, 8'h00);

    // R4 event during read
    @(negedge clk); rd_en = 1'b1; rd_addr = 5'h06; rx_valid = 1'b1; rx_data = 9'h013;
    #1 d = rd_data;
    check("R4 read shows old value", d, 8'h00);
    @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0;
    do_read(5'h06, d);
    check("R4 event survives read", d, 8'h04);

    // R8 break 8N1: L=10
    irq_mask = 6'h10;
    @(negedge clk); rx_line = 1'b0;
    ticks(10);
    #1 check("R8 no break at L ticks", {7'd0, spchar_irq}, 8'h00);
    ticks(1);
    #1 check("R8 break at L+1 ticks", {7'd0, spchar_irq}, 8'h01);
    do_read(5'h06, d);
    check("R8 break bit", d, 8'h10);
    ticks(15);
    #1 check("R9 no second break", {7'd0, spchar_irq}, 8'h00);
    @(negedge clk); rx_line = 1'b1;
    @(negedge clk); rx_line = 1'b0;
    ticks(11);
    #1 check("R9 re-armed after high", {7'd0, spchar_irq}, 8'h01);
    do_read(5'h06, d);

    // R8 5 data, parity, 2 stop: L=9
    @(negedge clk); rx_line = 1'b1; data_bits = 2'd0; parity_en = 1'b1; two_stop = 1'b1;
    @(negedge clk); rx_line = 1'b0;
    ticks(9);
    #1 check("R8 5E2 no break at 9", {7'd0, spchar_irq}, 8'h00);
    ticks(1);
    #1 check("R8 5E2 break at 10", {7'd0, spchar_irq}, 8'h01);
    @(negedge clk); rx_line = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule